// File: doc/BRIEF.md
# UART Modem Control and Local Loopback

This block holds the modem-control settings of a 16550-class serial port. It drives the active-low modem output pins and the serial transmit pin. It also decides what the receive shift register and the modem-status logic observe. A single-cycle write port loads six control bits: four modem controls, a local loopback switch and a remote echo switch. The settings can be read back at any time.

In normal operation the pins pass straight through. With local loopback on, the block forces the transmit pin and the four modem pins high. It sends the transmitter's serial output directly to the receiver, and it presents each modem control, in its asserted sense, to the matching status input. The interrupt logic downstream therefore sees looped status changes exactly as it would see external ones. Remote echo returns the received line to the transmit pin. Local loopback overrides it. The transmitter, receiver, baud generator and interrupt controller sit outside this block.

Top module: `uart_modem_loop`

## Requirements
- R1: While reset is asserted, and after it is released, all six control bits read 0. All four modem pins are 1, the transmit pin follows the transmitter output and status reflects the external pins. Asserting reset clears the bits at once, without waiting for a clock edge.
- R2: When `wr_en` is high at a rising edge, `wr_data` is loaded and appears on `ctrl_q` after that edge. The bit positions are 0 DTR, 1 RTS, 2 OUT1, 3 OUT2, 4 local loopback and 5 remote echo. When `wr_en` is low, the bits keep their values.
- R3: When local loopback is off, each modem pin is the inverse of its control bit: bit 1 gives a pin level of 0.
- R4: When both loopback bits are 0, `txd_pin` equals `tx_serial` and `rx_serial` equals `rxd_pin`. Each status output is the inverse of its external active-low pin: DSR, CTS, RI and DCD.
- R5: When local loopback is on, `txd_pin` and all four modem pins are 1.
- R6: When local loopback is on, `rx_serial` equals `tx_serial` and `rxd_pin` has no effect.
- R7: When local loopback is on, the status outputs are mapped as DSR = DTR bit, CTS = RTS bit, RI = OUT1 bit and DCD = OUT2 bit. The external modem inputs have no effect.
- R8: When remote echo is on and local loopback is off, `txd_pin` equals `rxd_pin`. The receiver still sees `rxd_pin` and the modem pins follow R3.
- R9: When both loopback bits are 1, the behaviour is that of local loopback alone.
- R10: A write that changes a mode or a control bit affects the pins and status outputs from the same edge that loads it. Before that edge, they show the old setting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| wr_en | input | 1 | Loads wr_data into the control bits |
| wr_data | input | 6 | New control bits (see R2 for positions) |
| ctrl_q | output | 6 | Current control bits |
| tx_serial | input | 1 | Serial output of the transmit shift register |
| rx_serial | output | 1 | Serial input to the receive shift register |
| txd_pin | output | 1 | External serial transmit pin |
| rxd_pin | input | 1 | External serial receive pin |
| dtr_n | output | 1 | Data terminal ready pin, active low |
| rts_n | output | 1 | Request to send pin, active low |
| out1_n | output | 1 | General output 1 pin, active low |
| out2_n | output | 1 | General output 2 pin, active low |
| dsr_n | input | 1 | Data set ready pin, active low |
| cts_n | input | 1 | Clear to send pin, active low |
| ri_n | input | 1 | Ring indicator pin, active low |
| dcd_n | input | 1 | Carrier detect pin, active low |
| st_dsr | output | 1 | DSR status to the modem-status logic, active high |
| st_cts | output | 1 | CTS status, active high |
| st_ri | output | 1 | RI status, active high |
| st_dcd | output | 1 | DCD status, active high |

## Verification
The hardest case to reach is a status change caused only by a looped control bit while every external modem input and the receive pin are held opposite to the value the loop should produce. Only that combination separates a correct mux from one that leaks a pin through. The stimulus writes control words with loopback set and, in the same vector, drives the external inputs to the opposite levels. It then rewrites a single control bit while loopback stays on and checks that only its mapped status output moves, sampled both just before and just after the loading edge. Writes with both loopback bits set cover the priority between the two loopback modes.

// File: rtl/uart_mloop_pkg.sv
package uart_mloop_pkg;
  localparam int CTRL_W  = 6;
  localparam int MODEM_W = 4;

  typedef struct packed {
    logic echo;
    logic lcl_lb;
    logic out2;
    logic out1;
    logic rts;
    logic dtr;
  } mctrl_t;
endpackage

// File: rtl/uart_mloop_rst_sync.sv
module uart_mloop_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_ok
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_ok = sync_q[STAGES-1];
endmodule

// File: rtl/uart_mloop_ctrl_reg.sv
module uart_mloop_ctrl_reg
  import uart_mloop_pkg::*;
(
  input  logic              clk,
  input  logic              rst_ok,
  input  logic              wr_en,
  input  logic [CTRL_W-1:0] wr_data,
  output mctrl_t            ctrl_q
);
  mctrl_t ctrl_d;

  always_comb begin
    ctrl_d = ctrl_q;
    if (wr_en) ctrl_d = mctrl_t'(wr_data);
  end

  always_ff @(posedge clk or negedge rst_ok) begin
    if (!rst_ok) ctrl_q <= '0;
    else         ctrl_q <= ctrl_d;
  end

  // R2
  wr_capture_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    wr_en |=> (ctrl_q == $past(wr_data)));

  // R2
  wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    !wr_en |=> $stable(ctrl_q));
endmodule

// File: rtl/uart_mloop_mux.sv
module uart_mloop_mux
  import uart_mloop_pkg::*;
(
  input  logic               clk,
  input  logic               rst_ok,
  input  mctrl_t             ctrl,
  input  logic               tx_serial,
  input  logic               rxd_pin,
  input  logic [MODEM_W-1:0] mdm_in_n,
  output logic               rx_serial,
  output logic               txd_pin,
  output logic [MODEM_W-1:0] mdm_out_n,
  output logic [MODEM_W-1:0] mdm_stat
);
  logic [MODEM_W-1:0] ctl_vec;

  assign ctl_vec = {ctrl.out2, ctrl.out1, ctrl.rts, ctrl.dtr};

  always_comb begin
    if (ctrl.lcl_lb) begin
      txd_pin   = 1'b1;
      rx_serial = tx_serial;
      mdm_out_n = '1;
      mdm_stat  = ctl_vec;
    end else begin
      txd_pin   = ctrl.echo ? rxd_pin : tx_serial;
      rx_serial = rxd_pin;
      mdm_out_n = ~ctl_vec;
      mdm_stat  = ~mdm_in_n;
    end
  end

  // R5
  lb_pins_high_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    ctrl.lcl_lb |-> (txd_pin && (mdm_out_n == '1)));

  // R6
  lb_rx_path_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    ctrl.lcl_lb |-> (rx_serial == tx_serial));

  // R7
  lb_stat_map_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    ctrl.lcl_lb |-> (mdm_stat[0] == ctrl.dtr && mdm_stat[3] == ctrl.out2));

  // R8
  echo_path_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    (ctrl.echo && !ctrl.lcl_lb) |-> (txd_pin == rxd_pin && rx_serial == rxd_pin));

  // R4
  normal_rx_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    !ctrl.lcl_lb |-> (rx_serial == rxd_pin));
endmodule

// File: rtl/uart_modem_loop.sv
module uart_modem_loop
  import uart_mloop_pkg::*;
#(
  parameter int RST_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [CTRL_W-1:0] wr_data,
  output logic [CTRL_W-1:0] ctrl_q,
  input  logic              tx_serial,
  output logic              rx_serial,
  output logic              txd_pin,
  input  logic              rxd_pin,
  output logic              dtr_n,
  output logic              rts_n,
  output logic              out1_n,
  output logic              out2_n,
  input  logic              dsr_n,
  input  logic              cts_n,
  input  logic              ri_n,
  input  logic              dcd_n,
  output logic              st_dsr,
  output logic              st_cts,
  output logic              st_ri,
  output logic              st_dcd
);
  logic               rst_ok;
  mctrl_t             ctrl;
  logic [MODEM_W-1:0] pins_n;
  logic [MODEM_W-1:0] stat;

  uart_mloop_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_ok (rst_ok)
  );

  uart_mloop_ctrl_reg u_reg (
    .clk     (clk),
    .rst_ok  (rst_ok),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .ctrl_q  (ctrl)
  );

  uart_mloop_mux u_mux (
    .clk       (clk),
    .rst_ok    (rst_ok),
    .ctrl      (ctrl),
    .tx_serial (tx_serial),
    .rxd_pin   (rxd_pin),
    .mdm_in_n  ({dcd_n, ri_n, cts_n, dsr_n}),
    .rx_serial (rx_serial),
    .txd_pin   (txd_pin),
    .mdm_out_n (pins_n),
    .mdm_stat  (stat)
  );

  assign ctrl_q = ctrl;
  assign {out2_n, out1_n, rts_n, dtr_n} = pins_n;
  assign {st_dcd, st_ri, st_cts, st_dsr} = stat;

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    !rst_ok |-> (ctrl_q == '0 && pins_n == '1));
endmodule

// File: tb/uart_modem_loop_tb.sv
module uart_modem_loop_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [5:0] wr_data = '0;
  logic [5:0] ctrl_q;
  logic tx_serial = 1'b0, rxd_pin = 1'b0;
  logic rx_serial, txd_pin;
  logic dtr_n, rts_n, out1_n, out2_n;
  logic dsr_n = 1'b1, cts_n = 1'b1, ri_n = 1'b1, dcd_n = 1'b1;
  logic st_dsr, st_cts, st_ri, st_dcd;
  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #5 clk = ~clk;

  uart_modem_loop u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .ctrl_q(ctrl_q),
    .tx_serial(tx_serial), .rx_serial(rx_serial), .txd_pin(txd_pin), .rxd_pin(rxd_pin),
    .dtr_n(dtr_n), .rts_n(rts_n), .out1_n(out1_n), .out2_n(out2_n),
    .dsr_n(dsr_n), .cts_n(cts_n), .ri_n(ri_n), .dcd_n(dcd_n),
    .st_dsr(st_dsr), .st_cts(st_cts), .st_ri(st_ri), .st_dcd(st_dcd)
  );

  // Vector: ctrl[21:16] tx[15] rxd[14] {dcd_n,ri_n,cts_n,dsr_n}[13:10]
  // expected {out2_n,out1_n,rts_n,dtr_n}[9:6] txd[5] rx[4] {dcd,ri,cts,dsr}[3:0]
  localparam int NV = 10;
  localparam logic [21:0] VEC [NV] = '{
    {6'b000000, 1'b1, 1'b0, 4'b1111, 4'b1111, 1'b1, 1'b0, 4'b0000},
    {6'b000101, 1'b0, 1'b1, 4'b0110, 4'b1010, 1'b0, 1'b1, 4'b1001},
    {6'b001010, 1'b1, 1'b1, 4'b1001, 4'b0101, 1'b1, 1'b1, 4'b0110},
    {6'b010000, 1'b0, 1'b1, 4'b0000, 4'b1111, 1'b1, 1'b0, 4'b0000},
    {6'b011010, 1'b1, 1'b0, 4'b1111, 4'b1111, 1'b1, 1'b1, 4'b1010},
    {6'b010101, 1'b0, 1'b0, 4'b1010, 4'b1111, 1'b1, 1'b0, 4'b0101},
    {6'b100011, 1'b1, 1'b0, 4'b1100, 4'b1100, 1'b0, 1'b0, 4'b0011},
    {6'b100000, 1'b0, 1'b1, 4'b1111, 4'b1111, 1'b1, 1'b1, 4'b0000},
    {6'b111111, 1'b0, 1'b1, 4'b0000, 4'b1111, 1'b1, 1'b0, 4'b1111},
    {6'b001111, 1'b0, 1'b0, 4'b1111, 4'b0000, 1'b0, 1'b0, 4'b0000}
  };

  task automatic chk(input string tag, input string what, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %b expected %b", tag, what, act, exp);
    end
  endtask

  task automatic write_ctrl(input logic [5:0] v);
    @(negedge clk);
    wr_en = 1'b1;
    wr_data = v;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  function automatic logic [3:0] pins();
    return {out2_n, out1_n, rts_n, dtr_n};
  endfunction

  function automatic logic [3:0] stat();
    return {st_dcd, st_ri, st_cts, st_dsr};
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (cyc > 5000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual %0d expected <=5000 cycles", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [5:0] c;
    string t;
    // R1 reset state, during reset
    #12;
    chk("R1", "ctrl in reset", {2'b0, ctrl_q}, 8'h00);
    chk("R1", "pins in reset", {4'b0, pins()}, 8'h0f);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    tx_serial = 1'b0;
    #1;
    chk("R1", "ctrl after release", {2'b0, ctrl_q}, 8'h00);
    chk("R1", "txd follows tx after release", {7'b0, txd_pin}, 8'h00);
    chk("R1", "status after release", {4'b0, stat()}, 8'h00);

    // Vector walk
    for (int i = 0; i < NV; i++) begin
      c = VEC[i][21:16];
      write_ctrl(c);
      tx_serial = VEC[i][15];
      rxd_pin = VEC[i][14];
      {dcd_n, ri_n, cts_n, dsr_n} = VEC[i][13:10];
      #1;
      t = (c[4] && c[5]) ? "R9" : "";
      chk("R2", "readback", {2'b0, ctrl_q}, {2'b0, c});
      chk(c[4] ? {t, "R5"} : "R3", "modem pins", {4'b0, pins()}, {4'b0, VEC[i][9:6]});
      chk(c[4] ? {t, "R5"} : (c[5] ? "R8" : "R4"), "txd_pin", {7'b0, txd_pin}, {7'b0, VEC[i][5]});
      chk(c[4] ? {t, "R6"} : "R4", "rx_serial", {7'b0, rx_serial}, {7'b0, VEC[i][4]});
      chk(c[4] ? {t, "R7"} : "R4", "status", {4'b0, stat()}, {4'b0, VEC[i][3:0]});
    end

    // R2 hold: data present but wr_en low
    @(negedge clk);
    wr_data = 6'b110000;
    @(negedge clk);
    @(negedge clk);
    chk("R2", "hold without wr_en", {2'b0, ctrl_q}, 8'h0f);

    // R6/R7 ignore external inputs while looping, then R10 single-bit change
    write_ctrl(6'b010000);
    rxd_pin = 1'b1; tx_serial = 1'b0;
    {dcd_n, ri_n, cts_n, dsr_n} = 4'b0000;
    #1;
    chk("R7", "external asserted ignored in loop", {4'b0, stat()}, 8'h00);
    chk("R6", "rxd ignored in loop", {7'b0, rx_serial}, 8'h00);
    @(negedge clk);
    wr_en = 1'b1;
    wr_data = 6'b010001;
    #1;
    chk("R10", "dsr before loading edge", {7'b0, st_dsr}, 8'h00);
    @(posedge clk);
    #1;
    chk("R10", "dsr after loading edge", {4'b0, stat()}, 8'h01);
    @(negedge clk);
    wr_en = 1'b0;
    wr_data = 6'b000001;
    @(negedge clk);
    wr_en = 1'b1;
    #1;
    chk("R10", "txd before leaving loop", {7'b0, txd_pin}, 8'h01);
    @(posedge clk);
    #1;
    chk("R10", "txd after leaving loop", {7'b0, txd_pin}, 8'h00);
    chk("R10", "dtr pin after leaving loop", {7'b0, dtr_n}, 8'h00);
    @(negedge clk);
    wr_en = 1'b0;

    // R1 asynchronous clear mid-cycle
    write_ctrl(6'b011111);
    #2;
    rst_n = 1'b0;
    #1;
    chk("R1", "async clear", {2'b0, ctrl_q}, 8'h00);
    chk("R1", "pins after async clear", {4'b0, pins()}, 8'h0f);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule